// File: doc/BRIEF.md
# Fractional Rate Divider with Committed Ratio Changes

This block derives a slower clock enable from its parent clock by letting through a chosen number of parent cycles out of every 32, spread as evenly as possible, and then thinning that stream by a fixed integer post-divider. The enable rate is therefore parent × mult / 32 / POST_DIV, with mult between 1 and 32. A phase accumulator adds mult every parent cycle and issues an enable on each carry. Over any 32 consecutive cycles, exactly mult enables come out.

Software programs the block through a small register port. The ratio is written as the 5-bit code 32 − mult into a field whose bit position is a parameter. The write lands in a staging register and leaves the running rate untouched. Setting a commit flag in a second register asks the datapath to take on the staged ratio. The datapath loads it only at the end of a 32-cycle window, so the enable pattern never shows a partial window. The commit flag clears itself one cycle later. While the flag is set, every register write is dropped and a sticky error flag is raised. A status register reports the ratio currently in use and the error flag.

Top module: `frac_rate_div`

## Requirements
- R1: After reset the staged code reads 0, the commit flag reads 0, the error flag reads 0, the active mult reads 32, and `rawEn` is high every cycle.
- R2: A write to address 0 while no commit is pending stores `wrData[FIELD_LSB+4:FIELD_LSB]` as the staged code. A read of address 0 returns that code at the same position, with all other bits 0.
- R3: Writing the staged code alone does not change the active mult or the output rate.
- R4: With code c active, any 32 consecutive cycles contain exactly 32 − c cycles with `rawEn` high.
- R5: With code c active, any 32·POST_DIV consecutive cycles contain exactly 32 − c cycles with `clkEn` high. `clkEn` is high only in cycles where `rawEn` is high.
- R6: Writing address 1 with bit 31 set, while no commit is pending, sets the commit flag. The flag reads back as bit 31 of address 1. It stays set until the new ratio is active and clears one cycle after that, within 34 cycles of the write.
- R7: The active mult changes only on the clock edge that ends a 32-cycle window. Windows are counted from the first edge after reset is released, so the change falls on an edge whose number is a multiple of 32.
- R8: Any write while the commit flag is set is ignored: the staged code, the commit flag and the active ratio are unchanged. The write sets the error flag, which stays set.
- R9: Writing address 2 with bit 8 set, while no commit is pending, clears the error flag.
- R10: A read of address 2 returns the active mult (1 to 32) in bits 5:0 and the error flag in bit 8, with all other bits 0.
- R11: A write to address 1 with bit 31 clear does not start a commit: the commit flag stays 0 and the active mult is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 ratio, 1 commit, 2 status |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read address, decoded combinationally |
| rdData | output | 32 | Read data |
| rawEn | output | 1 | Ratio enable before the post-divider |
| clkEn | output | 1 | Output clock enable after the post-divider |

## Verification
The bench builds the block with FIELD_LSB = 20 and POST_DIV = 3. The odd field position checks that the staged code is placed and returned at a shifted offset rather than at bit 0. The post-divider value of 3 is not a power of two, so the post-divider count must wrap at a non-binary boundary. Each table entry commits a new code and then counts `rawEn` over 32 cycles and `clkEn` over 96 cycles. The extreme codes (mult 1 and 32) are included. A cycle counter running from reset release confirms that each change lands on a window edge.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;

  localparam int RATIO_W = 5;
  localparam int WINDOW  = 1 << RATIO_W;
  localparam int MULT_W  = RATIO_W + 1;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_RATIO  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_KICK   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;

  localparam int KICK_BIT = 31;
  localparam int ERR_BIT  = 8;

  // control -> datapath strobes
  typedef struct packed {
    logic              commitReq;
    logic [MULT_W-1:0] newMult;
  } ctlToDp_t;

  // datapath -> control feedback
  typedef struct packed {
    logic              commitAck;
    logic [MULT_W-1:0] activeMult;
  } dpToCtl_t;

endpackage

// File: rtl/frac_rate_ctrl.sv
module frac_rate_ctrl
  import frac_rate_pkg::*;
#(
  parameter int FIELD_LSB = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  dpToCtl_t          dpStat,
  output ctlToDp_t          ctlOut
);

  logic [RATIO_W-1:0] shadowCode;
  logic               kickPend;
  logic               errFlag;
  logic               wrOpen;

  assign wrOpen = wrEn && !kickPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCode <= '0;
      kickPend   <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      if (wrEn && kickPend)
        errFlag <= 1'b1;
      else if (wrOpen && wrAddr == ADDR_STATUS && wrData[ERR_BIT])
        errFlag <= 1'b0;

      if (wrOpen && wrAddr == ADDR_RATIO)
        shadowCode <= wrData[FIELD_LSB +: RATIO_W];

      if (dpStat.commitAck)
        kickPend <= 1'b0;
      else if (wrOpen && wrAddr == ADDR_KICK && wrData[KICK_BIT])
        kickPend <= 1'b1;
    end
  end

  always_comb begin
    ctlOut.commitReq = kickPend;
    ctlOut.newMult   = MULT_W'(WINDOW) - {1'b0, shadowCode};
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_RATIO:  rdData[FIELD_LSB +: RATIO_W] = shadowCode;
      ADDR_KICK:   rdData[KICK_BIT] = kickPend;
      ADDR_STATUS: begin
        rdData[MULT_W-1:0] = dpStat.activeMult;
        rdData[ERR_BIT]    = errFlag;
      end
      default:     rdData = '0;
    endcase
  end

  AST_BUSY_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && kickPend) |=> errFlag); // R8
  AST_BUSY_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && kickPend) |=> $stable(shadowCode)); // R8
  AST_KICK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    dpStat.commitAck |=> !kickPend); // R6
  AST_KICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (kickPend && !dpStat.commitAck) |=> kickPend); // R6

endmodule

// File: rtl/frac_rate_dp.sv
module frac_rate_dp
  import frac_rate_pkg::*;
#(
  parameter int POST_DIV = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctlToDp_t ctlIn,
  output dpToCtl_t dpStat,
  output logic     rawEn,
  output logic     clkEn
);

  logic [RATIO_W-1:0] winCnt;
  logic [RATIO_W-1:0] phaseAcc;
  logic [MULT_W-1:0]  activeMult;
  logic [MULT_W-1:0]  phaseSum;
  logic               winEnd;
  logic               commitNow;
  logic               commitAck;

  assign winEnd    = &winCnt;
  assign commitNow = winEnd && ctlIn.commitReq;
  assign phaseSum  = {1'b0, phaseAcc} + activeMult;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt     <= '0;
      phaseAcc   <= '0;
      activeMult <= MULT_W'(WINDOW);
      rawEn      <= 1'b0;
      commitAck  <= 1'b0;
    end else begin
      winCnt    <= winCnt + 1'b1;
      phaseAcc  <= phaseSum[RATIO_W-1:0];
      rawEn     <= phaseSum[RATIO_W];
      commitAck <= commitNow;
      if (commitNow)
        activeMult <= ctlIn.newMult;
    end
  end

  generate
    if (POST_DIV <= 1) begin : g_noPost
      assign clkEn = rawEn;
    end else begin : g_post
      localparam int POST_W = $clog2(POST_DIV);
      localparam logic [POST_W-1:0] POST_LAST = POST_W'(POST_DIV - 1);
      logic [POST_W-1:0] postCnt;
      always_ff @(posedge clk) begin
        if (!rstN)
          postCnt <= '0;
        else if (rawEn)
          postCnt <= (postCnt == POST_LAST) ? '0 : postCnt + 1'b1;
      end
      assign clkEn = rawEn && (postCnt == POST_LAST);
    end
  endgenerate

  always_comb begin
    dpStat.commitAck  = commitAck;
    dpStat.activeMult = activeMult;
  end

  AST_MULT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (activeMult != $past(activeMult)) |-> ($past(winCnt) == '1)); // R7
  AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (activeMult >= 1) && (activeMult <= MULT_W'(WINDOW))); // R10
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rstN)
    (activeMult == MULT_W'(WINDOW)) |=> rawEn); // R4
  AST_OUT_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> rawEn); // R5

endmodule

// File: rtl/frac_rate_div.sv
module frac_rate_div
  import frac_rate_pkg::*;
#(
  parameter int FIELD_LSB = 8,
  parameter int POST_DIV  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        rawEn,
  output logic        clkEn
);

  ctlToDp_t ctlBus;
  dpToCtl_t dpBus;

  frac_rate_ctrl #(.FIELD_LSB(FIELD_LSB)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .dpStat (dpBus),
    .ctlOut (ctlBus)
  );

  frac_rate_dp #(.POST_DIV(POST_DIV)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctlIn  (ctlBus),
    .dpStat (dpBus),
    .rawEn  (rawEn),
    .clkEn  (clkEn)
  );

endmodule

// File: tb/test_frac_rate_div.sv
module test_frac_rate_div;

  localparam int FLSB  = 20;
  localparam int PDIV  = 3;
  localparam int NVEC  = 6;
  localparam logic [4:0] VCODE [NVEC] = '{5'd3, 5'd31, 5'd0, 5'd16, 5'd1, 5'd24};
  localparam int         VMULT [NVEC] = '{29, 1, 32, 16, 31, 8};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        rawEn;
  logic        clkEn;

  int nChk = 0;
  int nFail = 0;
  int edgeCnt = 0;
  int hitEdge;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  frac_rate_div #(.FIELD_LSB(FLSB), .POST_DIV(PDIV)) i_frac_rate_div (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .rawEn(rawEn), .clkEn(clkEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic countRaw(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rawEn) cnt++;
    end
  endtask

  task automatic countOut(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clkEn) cnt++;
    end
  endtask

  // Wait until status mult leaves oldMult; records edge number of the change
  task automatic waitChange(input int oldMult, output int newMult);
    logic [31:0] d;
    newMult = oldMult;
    hitEdge = -1;
    for (int i = 0; i < 1000; i++) begin
      regRead(2'd2, d);
      if (int'(d[5:0]) != oldMult) begin
        newMult = int'(d[5:0]);
        hitEdge = edgeCnt;
        break;
      end
      @(negedge clk);
    end
    if (hitEdge < 0) begin
      nChk++; nFail++;
      $display("FAIL R6: commit timed out, actual mult %0d expected change from %0d", newMult, oldMult);
    end
  endtask

  task automatic commitAndCheck(input logic [4:0] code, input int expMult, input int oldMult);
    logic [31:0] d;
    int got, cnt;
    regWrite(2'd0, 32'(code) << FLSB);
    regRead(2'd0, d);
    check("R2 ratio readback", d, 32'(code) << FLSB);
    regRead(2'd2, d);
    check("R3 no change before commit", 32'(d[5:0]), 32'(oldMult));
    regWrite(2'd1, 32'h8000_0000);
    regRead(2'd1, d);
    check("R6 commit flag set", d, 32'h8000_0000);
    waitChange(oldMult, got);
    check("R10 active mult", 32'(got), 32'(expMult));
    check("R7 change on window edge", 32'(hitEdge % 32), 32'd0);
    regRead(2'd1, d);
    check("R6 flag held one more cycle", d, 32'h8000_0000);
    @(negedge clk);
    regRead(2'd1, d);
    check("R6 flag self-cleared", d, 32'd0);
    @(negedge clk);
    countRaw(32, cnt);
    check("R4 raw pulses per window", 32'(cnt), 32'(expMult));
    countOut(32 * PDIV, cnt);
    check("R5 output pulses per 32*POST_DIV", 32'(cnt), 32'(expMult));
  endtask

  initial begin
    logic [31:0] d;
    int cnt, got, curMult;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    regRead(2'd0, d);  check("R1 ratio reset", d, 32'd0);
    regRead(2'd1, d);  check("R1 commit flag reset", d, 32'd0);
    regRead(2'd2, d);  check("R1 status reset", d, 32'd32);
    @(negedge clk);
    countRaw(32, cnt); check("R1 full rate after reset", 32'(cnt), 32'd32);

    // Table of ratio codes
    curMult = 32;
    for (int v = 0; v < NVEC; v++) begin
      commitAndCheck(VCODE[v], VMULT[v], curMult);
      curMult = VMULT[v];
    end

    // Writes while a commit is pending
    regWrite(2'd0, 32'd5 << FLSB);
    regWrite(2'd1, 32'h8000_0000);
    regWrite(2'd0, 32'd9 << FLSB);
    regRead(2'd0, d);  check("R8 staged code held while busy", d, 32'd5 << FLSB);
    regRead(2'd2, d);  check("R8 error flag raised", 32'(d[8]), 32'd1);
    waitChange(curMult, got);
    check("R8 committed value is pre-busy code", 32'(got), 32'd27);
    curMult = 27;
    repeat (3) @(negedge clk);
    regRead(2'd2, d);  check("R8 error flag sticky", 32'(d[8]), 32'd1);

    // Error clear
    regWrite(2'd2, 32'h0000_0100);
    regRead(2'd2, d);  check("R9 error cleared", d, 32'd27);

    // Commit write with bit 31 clear
    regWrite(2'd0, 32'd10 << FLSB);
    regWrite(2'd1, 32'h0000_0001);
    regRead(2'd1, d);  check("R11 no commit flag", d, 32'd0);
    repeat (70) @(negedge clk);
    regRead(2'd2, d);  check("R11 mult unchanged", 32'(d[5:0]), 32'd27);
    countRaw(32, cnt); check("R11 rate unchanged", 32'(cnt), 32'd27);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule